// File: doc/BRIEF.md
# Multi-function peripheral configuration unit

This block holds the configuration of a legacy multi-function peripheral controller: one parallel port, two serial ports, a floppy controller and an IDE controller. The host sees a two-byte I/O window. The even byte is an index port and the odd byte is a data port. An index value picks one of three 8-bit registers: function enable, function address and power/test. Reads of the index port first return a two-byte identification signature. After that they return the index that is currently selected.

On reset the three registers load values chosen by a 5-bit strap input. The block turns the packed register fields into per-function enables, I/O base addresses and IRQ numbers. Some of these decodes combine fields from more than one register. For each function, a chip-select output asserts when an incoming I/O address falls inside that function's window. Each register write that takes effect raises a one-cycle reconfigure pulse. The decoded outputs follow on the next clock. A lock bit freezes the registers until the next reset.

Top module: `sio_cfg`

## Requirements
- R1: With port_sel=0, a write stores the selected index. With port_sel=1, a write or read reaches the register named by that index. Index 0 is function enable, index 1 is function address and index 2 is power/test.
- R2: A data-port write while the selected index is above 2 changes no register and raises no reconfigure pulse. A data-port read at such an index returns 0x00.
- R3: After reset, the first index-port read returns 0x88 and the second returns 0x00. Later index-port reads return the selected index. Any index-port write ends this sequence at once.
- R4: Reset selects index 0 and loads the three registers from 32-entry tables indexed by strap. Strap 1 gives enable 0x4F, address 0x11 and power/test 0x00. Strap 31 gives 0x00, 0x10 and 0x02.
- R5: Enable bit3 turns on the floppy function. Its base is 0x370 when enable bit5=1 and 0x3F0 otherwise, and its IRQ is 6. Enable bit6 turns on the IDE function. Its base is 0x170 when enable bit7=1 and 0x1F0 otherwise. Its alternate-status base is that base plus 0x206, and its IRQ is 14.
- R6: The parallel port is enabled by enable bit0, and its code is address bits[1:0]. Code 0 gives base 0x378, with IRQ 7 when power/test bit3=1 and IRQ 5 otherwise. Code 1 gives 0x3BC with IRQ 7. Code 2 gives 0x278 with IRQ 5. Code 3 disables the port and gives base 0 and IRQ 0.
- R7: Serial port n (n=0,1) is enabled by enable bit(n+1), and its code is address bits[2n+3:2n+2]. Code 0 gives 0x3F8 and code 1 gives 0x2F8. For code 2, address bits[7:6] pick from 0x3E8/0x338/0x2E8/0x220. For code 3 they pick from 0x2E8/0x238/0x2E0/0x228. The IRQ is 3 for odd codes and 4 for even codes.
- R8: A register write that takes effect raises reconfig for exactly the following cycle. The decoded outputs reflect the new value one clock after the register changes.
- R9: Once power/test bit6 is 1, data-port writes are ignored and raise no pulse until the next reset.
- R10: A chip select is high only when its function is enabled and io_addr lies in [base, base+size). The size is 8 for the serial, floppy and IDE windows. The parallel window is 8 bytes, except at 0x3BC where it is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 5 | Reset-table selector |
| port_sel | input | 1 | Window address bit 0: 0 index, 1 data |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| io_addr | input | 16 | I/O address for chip-select decode |
| reconfig | output | 1 | One-cycle pulse after a register write |
| par_en | output | 1 | Parallel port enabled |
| par_base | output | 16 | Parallel base address |
| par_irq | output | 4 | Parallel IRQ |
| uart_en | output | 2 | Serial port enables |
| uart0_base | output | 16 | Serial port 0 base |
| uart0_irq | output | 4 | Serial port 0 IRQ |
| uart1_base | output | 16 | Serial port 1 base |
| uart1_irq | output | 4 | Serial port 1 IRQ |
| fdc_en | output | 1 | Floppy enabled |
| fdc_base | output | 16 | Floppy base |
| fdc_irq | output | 4 | Floppy IRQ |
| ide_en | output | 1 | IDE enabled |
| ide_base | output | 16 | IDE command base |
| ide_alt_base | output | 16 | IDE alternate-status base |
| ide_irq | output | 4 | IDE IRQ |
| cs_par | output | 1 | Parallel chip select |
| cs_uart | output | 2 | Serial chip selects |
| cs_fdc | output | 1 | Floppy chip select |
| cs_ide | output | 1 | IDE chip select |

## Verification
The assertions check the following on every cycle:
- a reconfigure pulse follows only a data-port write, and never one made while locked;
- an index-port read right after an index write echoes the written value;
- no chip select asserts while its function is disabled;
- serial IRQs stay at 3 or 4;
- data reads at unknown indices return zero.

Only the bench's scenarios can show the strap reset tables, the exact base and IRQ values for each address code, the dependence of the parallel IRQ on the power/test register, the edges of the chip-select windows, and the order of the identification reads.

// File: rtl/sio_cfg.sv
module sio_cfg #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] strap,
  input  logic          port_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] io_addr,
  output logic          reconfig,
  output logic          par_en,
  output logic [AW-1:0] par_base,
  output logic [3:0]    par_irq,
  output logic [1:0]    uart_en,
  output logic [AW-1:0] uart0_base,
  output logic [3:0]    uart0_irq,
  output logic [AW-1:0] uart1_base,
  output logic [3:0]    uart1_irq,
  output logic          fdc_en,
  output logic [AW-1:0] fdc_base,
  output logic [3:0]    fdc_irq,
  output logic          ide_en,
  output logic [AW-1:0] ide_base,
  output logic [AW-1:0] ide_alt_base,
  output logic [3:0]    ide_irq,
  output logic          cs_par,
  output logic [1:0]    cs_uart,
  output logic          cs_fdc,
  output logic          cs_ide
);

  localparam logic [1:0] ID_DONE = 2'd2;

  logic [DW-1:0] en_q, ad_q, pt_q, idx_q;
  logic [1:0]    id_q;
  logic          pulse_q;

  function automatic logic [7:0] en_init(input logic [4:0] s);
    if (s <= 5'd5)       return 8'h4F;
    else if (s <= 5'd11) return 8'h4B;
    else if (s <= 5'd15) return 8'h0F;
    else if (s <= 5'd19) return 8'h49;
    else if (s <= 5'd23) return 8'h07;
    else if (s <= 5'd29) return 8'h47;
    else if (s == 5'd30) return 8'h08;
    else                 return 8'h00;
  endfunction

  function automatic logic [7:0] ad_init(input logic [4:0] s);
    case (s)
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:      return 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:                   return 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:                   return 8'h24;
      5'd5, 5'd29:                                 return 8'h38;
      5'd6, 5'd16, 5'd19:                          return 8'h00;
      5'd7, 5'd8, 5'd17, 5'd18:                    return 8'h01;
      5'd9:                                        return 8'h09;
      5'd10, 5'd11:                                return 8'h08;
      default:                                     return 8'h10;
    endcase
  endfunction

  function automatic logic [AW-1:0] uart_base_f(input logic [1:0] code, input logic [1:0] sel);
    logic [15:0] b;
    case (code)
      2'd0: b = 16'h03F8;
      2'd1: b = 16'h02F8;
      2'd2: case (sel)
              2'd0: b = 16'h03E8;
              2'd1: b = 16'h0338;
              2'd2: b = 16'h02E8;
              default: b = 16'h0220;
            endcase
      default: case (sel)
              2'd0: b = 16'h02E8;
              2'd1: b = 16'h0238;
              2'd2: b = 16'h02E0;
              default: b = 16'h0228;
            endcase
    endcase
    return AW'(b);
  endfunction

  function automatic logic in_win(input logic [AW-1:0] a, input logic [AW-1:0] b, input int sz);
    return (a >= b) && ({1'b0, a} < ({1'b0, b} + (AW+1)'(sz)));
  endfunction

  wire data_wr = wr_en & port_sel;
  wire idx_wr  = wr_en & ~port_sel;
  wire idx_rd  = rd_en & ~port_sel;
  wire reg_wr  = data_wr & ~pt_q[6] & (idx_q < 8'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= en_init(strap);
      ad_q    <= ad_init(strap);
      pt_q    <= (strap == 5'd31) ? 8'h02 : 8'h00;
      idx_q   <= '0;
      id_q    <= 2'd0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= reg_wr;
      if (idx_wr) begin
        idx_q <= wr_data;
        id_q  <= ID_DONE;
      end else if (idx_rd && id_q != ID_DONE) begin
        id_q <= id_q + 2'd1;
      end
      if (reg_wr) begin
        case (idx_q[1:0])
          2'd0:    en_q <= wr_data;
          2'd1:    ad_q <= wr_data;
          default: pt_q <= wr_data;
        endcase
      end
    end
  end

  always_comb begin
    if (port_sel) begin
      case (idx_q)
        8'd0:    rd_data = en_q;
        8'd1:    rd_data = ad_q;
        8'd2:    rd_data = pt_q;
        default: rd_data = '0;
      endcase
    end else begin
      case (id_q)
        2'd0:    rd_data = 8'h88;
        2'd1:    rd_data = 8'h00;
        default: rd_data = idx_q;
      endcase
    end
  end

  logic [AW-1:0] d_pbase;
  logic [3:0]    d_pirq;
  always_comb begin
    case (ad_q[1:0])
      2'd0:    begin d_pbase = AW'(16'h0378); d_pirq = pt_q[3] ? 4'd7 : 4'd5; end
      2'd1:    begin d_pbase = AW'(16'h03BC); d_pirq = 4'd7; end
      2'd2:    begin d_pbase = AW'(16'h0278); d_pirq = 4'd5; end
      default: begin d_pbase = '0;            d_pirq = 4'd0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_en <= 1'b0; par_base <= '0; par_irq <= '0;
      uart_en <= '0; uart0_base <= '0; uart0_irq <= '0; uart1_base <= '0; uart1_irq <= '0;
      fdc_en <= 1'b0; fdc_base <= '0; fdc_irq <= '0;
      ide_en <= 1'b0; ide_base <= '0; ide_alt_base <= '0; ide_irq <= '0;
    end else begin
      par_en       <= en_q[0] & (ad_q[1:0] != 2'd3);
      par_base     <= d_pbase;
      par_irq      <= d_pirq;
      uart_en      <= en_q[2:1];
      uart0_base   <= uart_base_f(ad_q[3:2], ad_q[7:6]);
      uart0_irq    <= ad_q[2] ? 4'd3 : 4'd4;
      uart1_base   <= uart_base_f(ad_q[5:4], ad_q[7:6]);
      uart1_irq    <= ad_q[4] ? 4'd3 : 4'd4;
      fdc_en       <= en_q[3];
      fdc_base     <= en_q[5] ? AW'(16'h0370) : AW'(16'h03F0);
      fdc_irq      <= 4'd6;
      ide_en       <= en_q[6];
      ide_base     <= en_q[7] ? AW'(16'h0170) : AW'(16'h01F0);
      ide_alt_base <= en_q[7] ? AW'(16'h0376) : AW'(16'h03F6);
      ide_irq      <= 4'd14;
    end
  end

  assign reconfig   = pulse_q;
  assign cs_par     = par_en & in_win(io_addr, par_base, (par_base == AW'(16'h03BC)) ? 4 : 8);
  assign cs_uart[0] = uart_en[0] & in_win(io_addr, uart0_base, 8);
  assign cs_uart[1] = uart_en[1] & in_win(io_addr, uart1_base, 8);
  assign cs_fdc     = fdc_en & in_win(io_addr, fdc_base, 8);
  assign cs_ide     = ide_en & in_win(io_addr, ide_base, 8);

  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig |-> $past(data_wr));
  p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && pt_q[6]) |=> !reconfig);
  p_idx_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idx_wr) && !port_sel && !idx_wr) |-> rd_data == $past(wr_data));
  p_bad_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel && idx_q > 8'd2) |-> rd_data == '0);
  p_cs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_par -> par_en) && (cs_fdc -> fdc_en) && (cs_ide -> ide_en) && ((cs_uart & ~uart_en) == 2'b00));
  p_uart_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uart_en[0] |-> (uart0_irq == 4'd3 || uart0_irq == 4'd4));
  p_par_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    par_en |-> par_base != '0);

endmodule

// File: tb/sio_cfg_tb.sv
module sio_cfg_tb;
  logic clk = 0, rst_n = 0;
  logic [4:0] strap = 5'd1;
  logic port_sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [15:0] io_addr = 0;
  logic reconfig, par_en, fdc_en, ide_en, cs_par, cs_fdc, cs_ide;
  logic [1:0] uart_en, cs_uart;
  logic [15:0] par_base, uart0_base, uart1_base, fdc_base, ide_base, ide_alt_base;
  logic [3:0] par_irq, uart0_irq, uart1_irq, fdc_irq, ide_irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sio_cfg u_dut (.clk, .rst_n, .strap, .port_sel, .wr_en, .rd_en, .wr_data, .rd_data,
    .io_addr, .reconfig, .par_en, .par_base, .par_irq, .uart_en, .uart0_base, .uart0_irq,
    .uart1_base, .uart1_irq, .fdc_en, .fdc_base, .fdc_irq, .ide_en, .ide_base,
    .ide_alt_base, .ide_irq, .cs_par, .cs_uart, .cs_fdc, .cs_ide);

  typedef struct packed {
    logic [7:0] ad; logic [7:0] pt;
    logic [15:0] pb; logic [3:0] pi;
    logic [15:0] u0b; logic [3:0] u0i;
    logic [15:0] u1b; logic [3:0] u1i;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h00, 8'h00, 16'h0378, 4'd5, 16'h03F8, 4'd4, 16'h03F8, 4'd4},
    '{8'h24, 8'h08, 16'h0378, 4'd7, 16'h02F8, 4'd3, 16'h03E8, 4'd4},
    '{8'hF9, 8'h00, 16'h03BC, 4'd7, 16'h0220, 4'd4, 16'h0228, 4'd3},
    '{8'h7E, 8'h00, 16'h0278, 4'd5, 16'h0238, 4'd3, 16'h0238, 4'd3},
    '{8'h83, 8'h00, 16'h0000, 4'd0, 16'h03F8, 4'd4, 16'h03F8, 4'd4},
    '{8'hB8, 8'h00, 16'h0378, 4'd5, 16'h02E8, 4'd4, 16'h02E0, 4'd3}
  };

  task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] d, output logic rc);
    @(negedge clk); port_sel = p; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0; rc = reconfig;
  endtask

  task automatic rd(input logic p, output logic [7:0] d);
    @(negedge clk); port_sel = p; rd_en = 1; #1 d = rd_data;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk); rst_n = 0; strap = s;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic rc;
    do_reset(5'd1);
    // R4 reset contents for strap 1, R3 ID sequence
    rd(0, d); chk("R3 id byte 0", d, 8'h88);
    rd(0, d); chk("R3 id byte 1", d, 8'h00);
    rd(0, d); chk("R3/R4 index after id is 0", d, 8'h00);
    rd(1, d); chk("R4 strap1 enable", d, 8'h4F);
    wr(0, 8'd1, rc); rd(1, d); chk("R4 strap1 address", d, 8'h11);
    rd(0, d); chk("R1 index readback", d, 8'h01);
    wr(0, 8'd2, rc); rd(1, d); chk("R4 strap1 power/test", d, 8'h00);
    // R5 decoded from strap 1 enable 0x4F
    chk("R5 fdc_en strap1", fdc_en, 1); chk("R5 fdc_base strap1", fdc_base, 16'h03F0);
    chk("R5 ide_base strap1", ide_base, 16'h01F0);

    // R3 index write ends sequence immediately
    do_reset(5'd1);
    rd(0, d); chk("R3 first read after reset", d, 8'h88);
    wr(0, 8'd2, rc);
    rd(0, d); chk("R3 index write ends sequence", d, 8'h02);

    // R6 R7 vector table
    foreach (VECS[i]) begin
      wr(0, 8'd0, rc); wr(1, 8'h07, rc);
      chk($sformatf("R8 pulse after write v%0d", i), rc, 1);
      wr(0, 8'd1, rc); wr(1, VECS[i].ad, rc);
      wr(0, 8'd2, rc); wr(1, VECS[i].pt, rc);
      @(negedge clk);
      chk($sformatf("R8 pulse drops v%0d", i), reconfig, 0);
      chk($sformatf("R6 par_en v%0d", i), par_en, VECS[i].ad[1:0] != 2'd3);
      chk($sformatf("R6 par_base v%0d", i), par_base, VECS[i].pb);
      chk($sformatf("R6 par_irq v%0d", i), par_irq, VECS[i].pi);
      chk($sformatf("R7 uart0_base v%0d", i), uart0_base, VECS[i].u0b);
      chk($sformatf("R7 uart0_irq v%0d", i), uart0_irq, VECS[i].u0i);
      chk($sformatf("R7 uart1_base v%0d", i), uart1_base, VECS[i].u1b);
      chk($sformatf("R7 uart1_irq v%0d", i), uart1_irq, VECS[i].u1i);
      chk($sformatf("R7 uart_en v%0d", i), uart_en, 2'b11);
    end

    // R8 decode lag: write enable, check one cycle later state
    wr(0, 8'd0, rc); wr(1, 8'hE8, rc);
    chk("R8 pulse after enable write", rc, 1);
    @(negedge clk);
    chk("R5 fdc_base alt", fdc_base, 16'h0370); chk("R5 fdc_irq", fdc_irq, 4'd6);
    chk("R5 ide_base alt", ide_base, 16'h0170); chk("R5 ide_alt_base", ide_alt_base, 16'h0376);
    chk("R5 ide_irq", ide_irq, 4'd14); chk("R5 par off", par_en, 0);
    chk("R7 uart off", uart_en, 2'b00);
    // R10 windows (address reg 0xB8: par code 0 -> but enable off)
    io_addr = 16'h0370; #1 chk("R10 fdc low edge", cs_fdc, 1);
    io_addr = 16'h0377; #1 chk("R10 fdc high edge", cs_fdc, 1);
    io_addr = 16'h0378; #1 chk("R10 fdc past end", cs_fdc, 0);
    chk("R10 par disabled no cs", cs_par, 0);
    io_addr = 16'h016F; #1 chk("R10 ide below", cs_ide, 0);
    io_addr = 16'h0177; #1 chk("R10 ide top", cs_ide, 1);
    io_addr = 16'h0376; #1 chk("R10 ide alt not in cmd window", cs_ide, 0);
    wr(1, 8'hFF, rc);
    wr(0, 8'd1, rc); wr(1, 8'hF9, rc); @(negedge clk);
    io_addr = 16'h03BF; #1 chk("R10 par 3BC last byte", cs_par, 1);
    io_addr = 16'h03C0; #1 chk("R10 par 3BC size 4", cs_par, 0);
    io_addr = 16'h0220; #1 chk("R10 uart0 at 220", cs_uart, 2'b01);
    wr(1, 8'h00, rc); @(negedge clk);
    io_addr = 16'h037F; #1 chk("R10 par 378 size 8", cs_par, 1);
    io_addr = 16'h0380; #1 chk("R10 par 378 end", cs_par, 0);
    io_addr = 16'h03FF; #1 chk("R10 both uarts 3F8", cs_uart, 2'b11);

    // R2 unknown index
    wr(0, 8'd5, rc); wr(1, 8'hAA, rc);
    chk("R2 no pulse at bad index", rc, 0);
    rd(1, d); chk("R2 read bad index", d, 8'h00);
    wr(0, 8'd0, rc); rd(1, d); chk("R2 enable unchanged", d, 8'hFF);

    // R9 lock
    wr(0, 8'd2, rc); wr(1, 8'h40, rc);
    chk("R9 lock write takes effect", rc, 1);
    wr(0, 8'd0, rc); wr(1, 8'h00, rc);
    chk("R9 no pulse when locked", rc, 0);
    rd(1, d); chk("R9 enable kept", d, 8'hFF);
    wr(0, 8'd2, rc); wr(1, 8'h00, rc);
    rd(1, d); chk("R9 lock cannot be cleared", d, 8'h40);

    // R4 strap 31 and unlock by reset
    do_reset(5'd31);
    rd(1, d); chk("R4 strap31 enable", d, 8'h00);
    wr(0, 8'd1, rc); rd(1, d); chk("R4 strap31 address", d, 8'h10);
    wr(0, 8'd2, rc); rd(1, d); chk("R4 strap31 power/test", d, 8'h02);
    wr(1, 8'h00, rc); chk("R9 reset clears lock", rc, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule